// File: doc/BRIEF.md
# Cascadable Serial Configuration Memory Reader

This block is the read side of a serial configuration memory. It holds a bit array and an address counter, and it shifts one stored bit onto a serial data line for each rising edge of a configuration clock. The array is filled beforehand through a parallel preload port. Once the last bit has been passed, a chip-enable output goes active so that the next memory in a daisy chain can take over the data line.

A combined open-drain output-enable/reset pin is modelled as two signals: an input level and a drive-low request. When the pin is low, the counter returns to zero and the data line is released. The block pulls the pin low itself for as long as its own reset is held. A chip-enable input puts the block in standby. An in-system-programming enable releases the data line. A separate open-drain configuration pulse output can be pulsed low on request, which makes the target device restart its configuration.

The configuration clock is sampled synchronously on the system clock `clk`. A rising edge is detected when the sampled level goes from 0 to 1.

Top module: `cfg_serial_rom`

## Requirements
- R1: While `ce_n_i` is 0 and `oe_rst_i` is 1, each detected rising edge of `cclk_i` moves the address counter up by exactly one. With no edge, the counter holds.
- R2: While `oe_rst_i` is 0, the counter is cleared to address 0, `dout_en_o` is 0 and `ceo_n_o` is 1 in the same cycle. Configuration clock edges seen in this state do not advance the counter.
- R3: `oe_rst_drv_o` is 1 (pin pulled low) for the whole time `rst_n` is 0, and 0 once reset is released.
- R4: While `ce_n_i` is 1, the block is in standby. The counter is cleared to 0, clock edges are ignored, `dout_en_o` is 0 and `ceo_n_o` is 1.
- R5: `ceo_n_o` is 0 only when `ce_n_i` is 0, `oe_rst_i` is 1, and a rising clock edge has been seen while the counter was at the terminal count (DEPTH-1). It returns to 1 in the same cycle that either enable condition drops.
- R6: The counter stops at the terminal count and never wraps. Once it has gone past the terminal count, `dout_en_o` stays 0 until the counter is cleared.
- R7: While `isp_en_i` is 1, `dout_en_o` is 0. The counter address is unchanged, so the same bit reappears when the input is released.
- R8: When `dout_en_o` is 1, `dout_o` equals the array bit at the current counter address.
- R9: A preload write (`pre_we_i` = 1) stores `pre_bit_i` at `pre_addr_i` only while `ce_n_i` is 1. A write attempted while `ce_n_i` is 0 leaves the array unchanged.
- R10: A `cf_req_i` sampled at 1 while idle makes `cf_drv_o` 1 (pin pulled low) for exactly PULSE_CYC clocks, starting the cycle after the request. The pulse then releases.
- R11: A `cf_req_i` that arrives while a pulse is active is ignored, and the pulse length is not extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cclk_i | input | 1 | Configuration clock level, sampled on `clk` |
| ce_n_i | input | 1 | Active-low chip enable |
| oe_rst_i | input | 1 | Level seen on the output-enable/reset pin |
| oe_rst_drv_o | output | 1 | 1 pulls the output-enable/reset pin low |
| isp_en_i | input | 1 | In-system-programming enable; releases the data line |
| dout_o | output | 1 | Serial data bit |
| dout_en_o | output | 1 | Data driver enable (0 means high impedance) |
| ceo_n_o | output | 1 | Active-low chip-enable output to the next memory |
| cf_req_i | input | 1 | Request for a configuration pulse |
| cf_drv_o | output | 1 | 1 pulls the configuration pulse pin low |
| pre_we_i | input | 1 | Preload write strobe |
| pre_addr_i | input | $clog2(DEPTH) | Preload bit address |
| pre_bit_i | input | 1 | Preload bit value |

## Verification
The bench streams a preloaded pattern through the terminal count and beyond. A counter that wraps would bring the data line back to life at address 0, and one that stops a bit early would leave the chain output high. It drops `oe_rst_i` and `ce_n_i` in the middle of a stream and checks that the chain output releases in the same cycle and that the next bit comes from address 0. A registered cascade output, or a counter that keeps its position, would fail these checks. Preload writes while enabled, a programming-enable window and a repeated configuration request during an active pulse catch a design that corrupts the array, loses its place, or stretches the pulse.

// File: rtl/cfg_rom_pkg.sv
`timescale 1ns/1ps
package cfg_rom_pkg;

    // Width needed to hold values 0..n inclusive.
    function automatic int span_w(input int n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction

endpackage

// File: rtl/rom_addr_ctr.sv
`timescale 1ns/1ps
module rom_addr_ctr #(
    parameter int DEPTH = 1024
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cclk_i,
    input  logic                     run_i,
    output logic [$clog2(DEPTH)-1:0] addr_o,
    output logic                     past_tc_o
);
    localparam int AW = $clog2(DEPTH);
    localparam logic [AW-1:0] TC_A = AW'(DEPTH - 1);

    typedef struct packed {
        logic [AW-1:0] addr;
        logic          done;
        logic          cclk;
    } ctr_t;

    ctr_t st_d, st_q;
    logic rise;

    always_comb begin
        st_d      = st_q;
        st_d.cclk = cclk_i;
        rise      = cclk_i & ~st_q.cclk;
        if (!run_i) begin
            st_d.addr = '0;
            st_d.done = 1'b0;
        end else if (rise && !st_q.done) begin
            if (st_q.addr == TC_A) st_d.done = 1'b1;
            else                   st_d.addr = st_q.addr + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign addr_o    = st_q.addr;
    assign past_tc_o = st_q.done;

    AST_CTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && rise && !st_q.done && st_q.addr != TC_A) |=> (st_q.addr == $past(st_q.addr) + 1'b1)); // R1
    AST_CTR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> (st_q.addr == '0 && !st_q.done)); // R4
    AST_CTR_SATURATE: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.done |-> (st_q.addr == TC_A)); // R6
    AST_CTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && !rise) |=> $stable(st_q.addr)); // R1

endmodule

// File: rtl/rom_bit_array.sv
`timescale 1ns/1ps
module rom_bit_array #(
    parameter int DEPTH = 1024
) (
    input  logic                     clk,
    input  logic                     wr_ok_i,
    input  logic                     we_i,
    input  logic [$clog2(DEPTH)-1:0] wr_addr_i,
    input  logic                     wr_bit_i,
    input  logic [$clog2(DEPTH)-1:0] rd_addr_i,
    output logic                     rd_bit_o
);
    logic [DEPTH-1:0] mem_q;
    logic             wr_go;

    assign wr_go = we_i & wr_ok_i;

    always_ff @(posedge clk) begin
        if (wr_go) mem_q[wr_addr_i] <= wr_bit_i;
    end

    assign rd_bit_o = mem_q[rd_addr_i];

    AST_ARRAY_LOCKED: assert property (@(posedge clk)
        (we_i && !wr_ok_i) |=> $stable(mem_q)); // R9

endmodule

// File: rtl/rom_cfg_pulse.sv
`timescale 1ns/1ps
module rom_cfg_pulse
    import cfg_rom_pkg::*;
#(
    parameter int PULSE_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_i,
    output logic drv_o
);
    localparam int CW = span_w(PULSE_CYC);
    localparam logic [CW-1:0] LEN = CW'(PULSE_CYC);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (cnt_q != '0)  cnt_d = cnt_q - 1'b1;
        else if (req_i)   cnt_d = LEN;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign drv_o = (cnt_q != '0);

    AST_PULSE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LEN); // R10
    AST_PULSE_START: assert property (@(posedge clk) disable iff (!rst_n)
        (!drv_o && req_i) |=> (cnt_q == LEN)); // R10
    AST_PULSE_NO_RETRIGGER: assert property (@(posedge clk) disable iff (!rst_n)
        drv_o |=> (cnt_q == $past(cnt_q) - 1'b1)); // R11

endmodule

// File: rtl/cfg_serial_rom.sv
`timescale 1ns/1ps
module cfg_serial_rom #(
    parameter int DEPTH     = 1024,
    parameter int PULSE_CYC = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cclk_i,
    input  logic                     ce_n_i,
    input  logic                     oe_rst_i,
    output logic                     oe_rst_drv_o,
    input  logic                     isp_en_i,
    output logic                     dout_o,
    output logic                     dout_en_o,
    output logic                     ceo_n_o,
    input  logic                     cf_req_i,
    output logic                     cf_drv_o,
    input  logic                     pre_we_i,
    input  logic [$clog2(DEPTH)-1:0] pre_addr_i,
    input  logic                     pre_bit_i
);
    localparam int AW = $clog2(DEPTH);

    logic          run;
    logic [AW-1:0] addr;
    logic          past_tc;
    logic          rd_bit;

    assign run = ~ce_n_i & oe_rst_i;

    rom_addr_ctr #(.DEPTH(DEPTH)) u_ctr (
        .clk       (clk),
        .rst_n     (rst_n),
        .cclk_i    (cclk_i),
        .run_i     (run),
        .addr_o    (addr),
        .past_tc_o (past_tc)
    );

    rom_bit_array #(.DEPTH(DEPTH)) u_arr (
        .clk       (clk),
        .wr_ok_i   (ce_n_i),
        .we_i      (pre_we_i),
        .wr_addr_i (pre_addr_i),
        .wr_bit_i  (pre_bit_i),
        .rd_addr_i (addr),
        .rd_bit_o  (rd_bit)
    );

    rom_cfg_pulse #(.PULSE_CYC(PULSE_CYC)) u_pulse (
        .clk   (clk),
        .rst_n (rst_n),
        .req_i (cf_req_i),
        .drv_o (cf_drv_o)
    );

    assign oe_rst_drv_o = ~rst_n;
    assign dout_o       = rd_bit;
    assign dout_en_o    = run & ~isp_en_i & ~past_tc;
    assign ceo_n_o      = ~(run & past_tc);

    AST_CEO_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
        !ceo_n_o |-> (!ce_n_i && oe_rst_i)); // R5
    AST_CEO_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(dout_en_o && !ceo_n_o)); // R6
    AST_DATA_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        (isp_en_i || ce_n_i || !oe_rst_i) |-> !dout_en_o); // R7

endmodule

// File: tb/sim_cfg_serial_rom.sv
`timescale 1ns/1ps
module sim_cfg_serial_rom;
    localparam int DEPTH = 16;
    localparam int PULSE = 4;
    localparam int AW    = $clog2(DEPTH);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cclk = 1'b0, ce_n = 1'b1, oe = 1'b1, isp = 1'b0;
    logic cf_req = 1'b0, pre_we = 1'b0, pre_bit = 1'b0;
    logic [AW-1:0] pre_addr = '0;
    logic oe_drv, dout, dout_en, ceo_n, cf_drv;

    int n_chk = 0;
    int n_fail = 0;
    bit model [DEPTH];

    typedef struct { bit d; bit en; bit ceo; string req; } exp_t;
    exp_t exp_q[$];

    always #2.5 clk = ~clk;

    cfg_serial_rom #(.DEPTH(DEPTH), .PULSE_CYC(PULSE)) u0 (
        .clk(clk), .rst_n(rst_n), .cclk_i(cclk), .ce_n_i(ce_n), .oe_rst_i(oe),
        .oe_rst_drv_o(oe_drv), .isp_en_i(isp), .dout_o(dout), .dout_en_o(dout_en),
        .ceo_n_o(ceo_n), .cf_req_i(cf_req), .cf_drv_o(cf_drv),
        .pre_we_i(pre_we), .pre_addr_i(pre_addr), .pre_bit_i(pre_bit)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Monitor: pops one expected item per sampled cycle.
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            chk(dout_en == e.en, {e.req, " data enable"}, int'(dout_en), int'(e.en));
            chk(ceo_n == e.ceo, {e.req, " chain out"}, int'(ceo_n), int'(e.ceo));
            if (e.en) chk(dout == e.d, {e.req, " data bit"}, int'(dout), int'(e.d));
        end
    end

    task automatic tick();
        @(posedge clk); #1;
    endtask

    // Driver: one configuration clock pulse, then push the expected result.
    task automatic step(input bit d, input bit en, input bit ceo, input string req);
        cclk = 1'b1;
        tick();
        cclk = 1'b0;
        exp_q.push_back('{d: d, en: en, ceo: ceo, req: req});
        tick();
    endtask

    task automatic expect_now(input bit d, input bit en, input bit ceo, input string req);
        exp_q.push_back('{d: d, en: en, ceo: ceo, req: req});
        tick();
    endtask

    task automatic pulse_run(input bit retrig, input string req);
        int hi = 0;
        cf_req = 1'b1;
        tick();
        cf_req = 1'b0;
        for (int k = 0; k < 2 * PULSE; k++) begin
            @(negedge clk);
            hi += int'(cf_drv);
            tick();
            cf_req = retrig && (k == 1);
        end
        cf_req = 1'b0;
        chk(hi == PULSE, req, hi, PULSE);
    endtask

    initial begin
        #1000000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) model[i] = ((i % 3) == 0) ^ (i > 7);

        // R3: pin pulled low while in reset
        repeat (3) @(posedge clk);
        #1;
        chk(oe_drv == 1'b1, "R3 in reset", int'(oe_drv), 1);
        chk(cf_drv == 1'b0, "R10 idle in reset", int'(cf_drv), 0);
        rst_n = 1'b1;
        tick();
        chk(oe_drv == 1'b0, "R3 after reset", int'(oe_drv), 0);

        // Preload the array with chip enable high
        for (int i = 0; i < DEPTH; i++) begin
            pre_we = 1'b1; pre_addr = AW'(i); pre_bit = model[i];
            tick();
        end
        pre_we = 1'b0;

        // R8: address 0 visible once enabled
        ce_n = 1'b0;
        expect_now(model[0], 1'b1, 1'b1, "R8 first bit");

        // R1/R8: stream to the terminal count
        for (int a = 1; a < DEPTH; a++) step(model[a], 1'b1, 1'b1, "R1 stream");
        // R5: passing the terminal count hands over the chain
        step(1'b0, 1'b0, 1'b0, "R5 past terminal count");
        // R6: further edges do not wrap
        step(1'b0, 1'b0, 1'b0, "R6 saturate");
        step(1'b0, 1'b0, 1'b0, "R6 saturate again");

        // R2: pin low releases chain out immediately
        oe = 1'b0;
        #1;
        chk(ceo_n == 1'b1, "R2 chain out releases", int'(ceo_n), 1);
        chk(dout_en == 1'b0, "R2 data released", int'(dout_en), 0);
        tick();
        step(1'b0, 1'b0, 1'b1, "R2 edge ignored");
        oe = 1'b1;
        expect_now(model[0], 1'b1, 1'b1, "R2 counter cleared");

        // R1 again, then R7
        for (int a = 1; a <= 5; a++) step(model[a], 1'b1, 1'b1, "R1 restart");
        isp = 1'b1;
        expect_now(1'b0, 1'b0, 1'b1, "R7 programming enable");
        tick();
        isp = 1'b0;
        expect_now(model[5], 1'b1, 1'b1, "R7 address kept");
        tick(); tick();
        expect_now(model[5], 1'b1, 1'b1, "R1 hold without edge");

        // R4: standby clears counter and ignores edges
        ce_n = 1'b1;
        expect_now(1'b0, 1'b0, 1'b1, "R4 standby");
        step(1'b0, 1'b0, 1'b1, "R4 edge in standby");
        ce_n = 1'b0;
        expect_now(model[0], 1'b1, 1'b1, "R4 counter cleared");
        step(model[1], 1'b1, 1'b1, "R4 restart from zero");

        // R9: preload ignored while enabled, accepted in standby
        oe = 1'b0; tick(); oe = 1'b1; tick();
        pre_we = 1'b1; pre_addr = '0; pre_bit = ~model[0];
        tick();
        pre_we = 1'b0;
        expect_now(model[0], 1'b1, 1'b1, "R9 write ignored");
        ce_n = 1'b1;
        pre_we = 1'b1; pre_addr = '0; pre_bit = ~model[0];
        tick();
        pre_we = 1'b0;
        model[0] = ~model[0];
        ce_n = 1'b0;
        expect_now(model[0], 1'b1, 1'b1, "R9 write accepted");

        // R10/R11: configuration pulse
        pulse_run(1'b0, "R10 pulse length");
        pulse_run(1'b1, "R11 retrigger ignored");
        @(negedge clk);
        chk(cf_drv == 1'b0, "R10 pulse released", int'(cf_drv), 0);

        tick(); tick();
        chk(exp_q.size() == 0, "R8 scoreboard drained", exp_q.size(), 0);
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

endmodule